// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a 64-bit count of nanoseconds for precision time stamping. Each timing-clock cycle in which counting is enabled, it adds a fixed-point step to the count. The step has 32 whole-nanosecond bits and 32 fraction bits. A hidden 32-bit fraction register collects the sub-nanosecond remainder and carries into the count, so the average rate matches the programmed step with no long-run drift. For example, a step of 0x0199999999 gives 1.6 ns per cycle, 0x0333333333 gives 3.2 ns and 0x2000000000 gives 32 ns. The current count is driven continuously on `time_ns` for timestamp units.

Software reaches the block through a plain 32-bit register port. A write or a read is a single-cycle strobe. The port never stalls and has no back-pressure. Read data appears on `reg_rdata` one cycle after the strobe and holds until the next read.

Wide values move as two 32-bit halves in a fixed order:
- **Loading the time:** write the low half first. The new value takes effect when the high half is written.
- **Loading the step:** write the low half first. The new step takes effect when the high half is written.
- **Reading the time:** read the low half first. That read freezes the upper half, and a later read of the high half returns the frozen value.

Software adjusts frequency by loading a scaled step and adjusts phase by reading, adding and rewriting the time.

Top module: `nsclk_top`

## Requirements
- R1: After reset the count, the hidden fraction and the read data are zero, counting is disabled and the step reads back as 0x00000001_99999999.
- R2: With counting enabled and no time load, each clock adds the 64-bit step to the 96-bit value {count, fraction}, so the count advances by the whole part or the whole part plus one.
- R3: With counting disabled, the count holds its value.
- R4: A write to address 1 (time low half) stores that half only and leaves the count unchanged.
- R5: A write to address 2 (time high half) loads {write data, stored low half} into the count at that clock edge and clears the fraction. It takes priority over the increment in that cycle.
- R6: A write to address 3 (step low half) alone does not change the active step. A write to address 4 (step high half) commits {write data, stored low half} as the new step.
- R7: A step of zero stops the count even while counting is enabled.
- R8: A read of address 1 returns the low 32 bits of the count sampled at that clock edge and captures the upper 32 bits. A later read of address 2 returns the captured word, even if the count has moved on since.
- R9: Read data is valid one cycle after the read strobe. Address 0 reads the enable in bit 0, which is set by bit 0 of a write to address 0. Address 3 reads the active step's low half and address 4 reads its high half.
- R10: The fraction carries into the count. After a load followed by N increments of step I, the count equals the loaded value plus floor(N·I / 2^32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one step is added per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 enable, 1 time low, 2 time high, 3 step low, 4 step high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| time_ns | output | 64 | Current nanosecond count |

## Verification
Each result has a fixed latency:
- A time load, an enable change or a step commit takes effect at the clock edge of its write. The count seen after that edge is exactly the loaded value.
- From then on, each later edge adds one step.
- Read data is due at the first sample point after the strobe's edge.

The bench drives every input at the falling edge and samples at the next falling edge. It therefore counts exactly how many rising edges lie between a load and a check. It predicts the count as the loaded value plus floor(N·step / 2^32) for N counted edges. The snapshot check takes the read edge's own pre-update value as its reference.

// File: rtl/nsclk_pkg.sv
package nsclk_pkg;

  localparam int REG_AW = 3;

  // Register addresses; the low half of each pair sits below its high half.
  typedef enum logic [REG_AW-1:0] {
    ADR_CTRL    = 3'd0,
    ADR_TIME_LO = 3'd1,
    ADR_TIME_HI = 3'd2,
    ADR_STEP_LO = 3'd3,
    ADR_STEP_HI = 3'd4
  } reg_addr_e;

endpackage

// File: rtl/nsclk_split_reg.sv
// Wide value written as two halves: the low half is staged, the high-half
// write commits. HOLD=1 keeps the committed value in a register, HOLD=0
// passes {wdata, staged low} through for a one-cycle load.
module nsclk_split_reg #(
  parameter int                  HALF_W  = 32,
  parameter bit                  HOLD    = 1'b1,
  parameter logic [2*HALF_W-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  output logic                commit,
  output logic [2*HALF_W-1:0] value
);

  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] lo_stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     lo_stage_q <= RST_VAL[HALF_W-1:0];
    else if (wr_lo) lo_stage_q <= wdata;
  end

  assign commit = wr_hi;

  generate
    if (HOLD) begin : g_hold
      logic [FULL_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (!rst_n)     val_q <= RST_VAL;
        else if (wr_hi) val_q <= {wdata, lo_stage_q};
      end
      assign value = val_q;
    end else begin : g_pass
      assign value = {wdata, lo_stage_q};
    end
  endgenerate

endmodule

// File: rtl/nsclk_accum.sv
// {count, fraction} accumulator; a load clears the fraction and wins over run.
module nsclk_accum #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [2*BUS_W-1:0] step,
  input  logic               load,
  input  logic [2*BUS_W-1:0] load_val,
  output logic [2*BUS_W-1:0] count
);

  localparam int ACC_W = 3 * BUS_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;

  assign acc_next = acc_q + {{BUS_W{1'b0}}, step};

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= {load_val, {BUS_W{1'b0}}};
    else if (run)  acc_q <= acc_next;
  end

  assign count = acc_q[ACC_W-1:BUS_W];

endmodule

// File: rtl/nsclk_readout.sv
// Registered read mux with the upper-word snapshot taken on a low-half read.
module nsclk_readout
  import nsclk_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  reg_addr_e          addr,
  input  logic [2*BUS_W-1:0] count,
  input  logic [2*BUS_W-1:0] step,
  input  logic               run,
  output logic [BUS_W-1:0]   rdata,
  output logic [BUS_W-1:0]   snap_hi
);

  logic [BUS_W-1:0] sel;

  always_comb begin
    unique case (addr)
      ADR_CTRL:    sel = {{(BUS_W-1){1'b0}}, run};
      ADR_TIME_LO: sel = count[BUS_W-1:0];
      ADR_TIME_HI: sel = snap_hi;
      ADR_STEP_LO: sel = step[BUS_W-1:0];
      ADR_STEP_HI: sel = step[2*BUS_W-1:BUS_W];
      default:     sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      snap_hi <= '0;
    end else if (rd) begin
      rdata <= sel;
      if (addr == ADR_TIME_LO) snap_hi <= count[2*BUS_W-1:BUS_W];
    end
  end

endmodule

// File: rtl/nsclk_top.sv
module nsclk_top
  import nsclk_pkg::*;
#(
  parameter int             BUS_W    = 32,
  parameter logic [2*BUS_W-1:0] STEP_RST = 64'h0000_0001_9999_9999
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [BUS_W-1:0]   reg_wdata,
  output logic [BUS_W-1:0]   reg_rdata,
  output logic [2*BUS_W-1:0] time_ns
);

  localparam int WIDE_W = 2 * BUS_W;

  reg_addr_e         addr_e;
  logic              run_q;
  logic              time_load;
  logic [WIDE_W-1:0] time_new;
  logic              step_commit;
  logic [WIDE_W-1:0] step_val;
  logic [BUS_W-1:0]  snap_hi;

  assign addr_e = reg_addr_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)                             run_q <= 1'b0;
    else if (reg_wr && addr_e == ADR_CTRL) run_q <= reg_wdata[0];
  end

  nsclk_split_reg #(.HALF_W(BUS_W), .HOLD(1'b0), .RST_VAL('0)) u_time_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (reg_wr && addr_e == ADR_TIME_LO),
    .wr_hi  (reg_wr && addr_e == ADR_TIME_HI),
    .wdata  (reg_wdata),
    .commit (time_load),
    .value  (time_new)
  );

  nsclk_split_reg #(.HALF_W(BUS_W), .HOLD(1'b1), .RST_VAL(STEP_RST)) u_step_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (reg_wr && addr_e == ADR_STEP_LO),
    .wr_hi  (reg_wr && addr_e == ADR_STEP_HI),
    .wdata  (reg_wdata),
    .commit (step_commit),
    .value  (step_val)
  );

  nsclk_accum #(.BUS_W(BUS_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .step     (step_val),
    .load     (time_load),
    .load_val (time_new),
    .count    (time_ns)
  );

  nsclk_readout #(.BUS_W(BUS_W)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (reg_rd),
    .addr    (addr_e),
    .count   (time_ns),
    .step    (step_val),
    .run     (run_q),
    .rdata   (reg_rdata),
    .snap_hi (snap_hi)
  );

endmodule

// File: rtl/nsclk_chk.sv
module nsclk_chk #(
  parameter int BUS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [2:0]         reg_addr,
  input logic [BUS_W-1:0]   reg_wdata,
  input logic [BUS_W-1:0]   reg_rdata,
  input logic [2*BUS_W-1:0] time_ns,
  input logic               run,
  input logic [2*BUS_W-1:0] step,
  input logic               step_commit,
  input logic [BUS_W-1:0]   snap_hi
);

  logic hi_load, lo_write, hi_read, lo_read;
  logic [2*BUS_W-1:0] step_whole;

  assign hi_load    = reg_wr && reg_addr == 3'd2;
  assign lo_write   = reg_wr && reg_addr == 3'd1;
  assign hi_read    = reg_rd && reg_addr == 3'd2;
  assign lo_read    = reg_rd && reg_addr == 3'd1;
  assign step_whole = {{BUS_W{1'b0}}, step[2*BUS_W-1:BUS_W]};

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hi_load) |=> ((time_ns - $past(time_ns)) == $past(step_whole)) ||
                          ((time_ns - $past(time_ns)) == $past(step_whole) + 1'b1));

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hi_load) |=> $stable(time_ns));

  p_lo_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_write && !run) |=> $stable(time_ns));

  p_hi_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> time_ns[2*BUS_W-1:BUS_W] == $past(reg_wdata));

  p_step_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_commit |=> $stable(step));

  p_zero_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0 && !hi_load) |=> $stable(time_ns));

  p_snap_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_read |=> reg_rdata == $past(snap_hi));

  p_lo_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_read |=> reg_rdata == $past(time_ns[BUS_W-1:0]));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

bind nsclk_top nsclk_chk #(.BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .time_ns     (time_ns),
  .run         (run_q),
  .step        (step_val),
  .step_commit (step_commit),
  .snap_hi     (snap_hi)
);

// File: tb/sim_nsclk_top.sv
`timescale 1ns/1ps
module sim_nsclk_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_ns;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  nsclk_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_ns(time_ns)
  );

  // step, start time, enabled edges, expected count
  localparam int NV = 5;
  localparam logic [63:0] V_STEP  [NV] = '{64'h0000_0001_9999_9999, 64'h0000_0003_3333_3333,
                                           64'h0000_0020_0000_0000, 64'h0000_0001_0000_0000,
                                           64'h0000_0000_8000_0000};
  localparam logic [63:0] V_START [NV] = '{64'd0, 64'd100, 64'h0000_0000_FFFF_FFF0,
                                           64'hFFFF_FFFF_FFFF_FFFE, 64'd7};
  localparam int          V_TICKS [NV] = '{10, 10, 4, 3, 5};
  localparam logic [63:0] V_EXP   [NV] = '{64'd15, 64'd131, 64'h0000_0001_0000_0070,
                                           64'd1, 64'd9};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] t0;
    wait_edges(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R9 readback
    chk("R1 count", time_ns, 64'd0);
    chk("R1 rdata", {32'd0, reg_rdata}, 64'd0);
    rd(3'd0, r); chk("R1 R9 enable", {32'd0, r}, 64'd0);
    rd(3'd3, r); chk("R1 R9 step lo", {32'd0, r}, 64'h9999_9999);
    rd(3'd4, r); chk("R1 R9 step hi", {32'd0, r}, 64'd1);

    // R4 low half only, R3 hold, R5 commit
    wr(3'd1, 32'h0000_1234);
    chk("R4 low half no load", time_ns, 64'd0);
    wait_edges(5);
    chk("R3 disabled hold", time_ns, 64'd0);
    wr(3'd2, 32'h5);
    chk("R5 time load", time_ns, 64'h0000_0005_0000_1234);
    wait_edges(4);
    chk("R3 disabled hold after load", time_ns, 64'h0000_0005_0000_1234);

    // vector table: R2 R10 rate and fraction carry
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, 32'd0);
      wr(3'd3, V_STEP[v][31:0]);
      wr(3'd4, V_STEP[v][63:32]);
      wr(3'd1, V_START[v][31:0]);
      wr(3'd2, V_START[v][63:32]);
      wr(3'd0, 32'd1);
      wait_edges(V_TICKS[v]);
      chk($sformatf("R2 R10 vector %0d", v), time_ns, V_EXP[v]);
    end

    // counting enabled with 0.5 ns step; R6 low half alone not committed
    wr(3'd3, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h10);
    chk("R5 load while running", time_ns, 64'h0000_0010_0000_0000);
    wait_edges(4);
    chk("R6 step low half alone", time_ns, 64'h0000_0010_0000_0002);
    wr(3'd4, 32'd1);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h20);
    wait_edges(4);
    chk("R6 step commit", time_ns, 64'h0000_0020_0000_0004);
    rd(3'd4, r); chk("R9 step hi read", {32'd0, r}, 64'd1);
    rd(3'd3, r); chk("R9 step lo read", {32'd0, r}, 64'd0);
    rd(3'd0, r); chk("R9 enable read", {32'd0, r}, 64'd1);

    // R8 snapshot across an upper-word change, 32 ns step
    wr(3'd3, 32'd0);
    wr(3'd4, 32'h20);
    wr(3'd1, 32'hFFFF_FFE0);
    wr(3'd2, 32'd0);
    rd(3'd1, r); chk("R8 low read", {32'd0, r}, 64'hFFFF_FFE0);
    chk("R2 step after read", time_ns, 64'h0000_0001_0000_0000);
    t0 = time_ns;
    @(negedge clk);
    chk("R2 one edge", time_ns - t0, 64'd32);
    wait_edges(2);
    chk("R8 upper moved", {32'd0, time_ns[63:32]}, 64'd1);
    rd(3'd2, r); chk("R8 snapshot high", {32'd0, r}, 64'd0);
    rd(3'd1, r);
    rd(3'd2, r); chk("R8 fresh snapshot high", {32'd0, r}, 64'd1);

    // R7 zero step stops the clock while enabled
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd0);
    t0 = time_ns;
    wait_edges(6);
    chk("R7 zero step", time_ns, t0);

    // R3 disable holds a running count
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd3);
    wr(3'd0, 32'd0);
    t0 = time_ns;
    wait_edges(5);
    chk("R3 disable holds", time_ns, t0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule